// File: doc/BRIEF.md
# Synchronous Dual-Port RAM with Per-Port Output Latency

This block is a byte-wide RAM with two fully independent ports. Both ports can reach every location, and both can reach the same location in the same cycle. Each port has its own clock. On the rising edge of that clock it samples its chip enables, its read/write flag, its write byte and its address controls. Each port also takes a static mode input. The mode picks flow-through reads, where data follows the address edge, or pipelined reads, which add one output register and one cycle of latency.

There is no tri-state bus. Each port returns its read byte on a dedicated output, and a drive flag tells the surrounding logic when that byte would be driven. The output enable gates the flag without passing through a clock. The address of each port comes from a small per-port counter. On each edge the counter can clear to zero, load the address pins, step by one or hold, so burst transfers need no new address on every cycle.

The default depth is 1K locations. The address width is a parameter, so the full 128K x 8 array is reached by setting it to 17.

Top module: `dpram_sync`

## Requirements
- R1: While reset is low, and after it is released until the first selected read, both drive flags are low. Each port's address counter restarts at 0.
- R2: A port is selected when chip enable 0 is low and chip enable 1 is high. A selected cycle with the read/write flag low stores the write byte at the address chosen on that edge. Later reads of that address return the stored byte.
- R3: On each edge the port address is chosen in this priority: clear gives 0, then load gives the address pins, then step gives the previous address plus one, otherwise the previous address is kept.
- R4: The address counter obeys R3 whether or not the port is selected, and stepping from the top location wraps to 0.
- R5: In flow-through mode (mode input 0), the read data for the address chosen at edge k is present on the data output from edge k onward.
- R6: In pipelined mode (mode input 1), the same data appears one edge later, at edge k+1.
- R7: In flow-through mode the drive flag is high after edge k only if edge k sampled a selected read. A deselect or a write turns it off after that edge.
- R8: In pipelined mode the drive flag is high after edge k only if edge k-1 sampled a selected read and edge k also sampled a selected cycle. After a deselect, two consecutive selected cycles are needed before the output drives again.
- R9: A high output enable forces the drive flag low at once, without a clock edge, and leaves the data output unchanged.
- R10: When neither clear, load nor step is asserted and no write occurs, the data output keeps its value on later edges.
- R11: A write on one port to the address that the other port reads on the same edge, or on a later edge, is seen by that read.
- R12: When both ports write the same address on the same edge, the byte of the port named by parameter `WIN_PORT` (0 = port A, 1 = port B) is stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clkA | input | 1 | Port A clock |
| clkB | input | 1 | Port B clock |
| rstN | input | 1 | Active-low asynchronous reset for the control state of both ports |
| aCe0N | input | 1 | Port A chip enable, active low |
| aCe1 | input | 1 | Port A chip enable, active high |
| aRdWrN | input | 1 | Port A read (1) or write (0) |
| aOeN | input | 1 | Port A output enable, active low, unclocked |
| aPipeMode | input | 1 | Port A latency mode: 0 flow-through, 1 pipelined; static |
| aAddrClear | input | 1 | Port A counter clear to 0 |
| aAddrLoad | input | 1 | Port A counter load from aAddr |
| aAddrStep | input | 1 | Port A counter increment |
| aAddr | input | ADDR_W | Port A address pins |
| aWrData | input | DATA_W | Port A write byte |
| aRdData | output | DATA_W | Port A read byte |
| aRdDrive | output | 1 | Port A output drive flag |
| bCe0N | input | 1 | Port B chip enable, active low |
| bCe1 | input | 1 | Port B chip enable, active high |
| bRdWrN | input | 1 | Port B read (1) or write (0) |
| bOeN | input | 1 | Port B output enable, active low, unclocked |
| bPipeMode | input | 1 | Port B latency mode: 0 flow-through, 1 pipelined; static |
| bAddrClear | input | 1 | Port B counter clear to 0 |
| bAddrLoad | input | 1 | Port B counter load from bAddr |
| bAddrStep | input | 1 | Port B counter increment |
| bAddr | input | ADDR_W | Port B address pins |
| bWrData | input | DATA_W | Port B write byte |
| bRdData | output | DATA_W | Port B read byte |
| bRdDrive | output | 1 | Port B output drive flag |

## Verification
A wrong counter value shows on the data output at the edge that chose the address in flow-through mode, and one edge later in pipelined mode. For this reason the bench predicts the data byte and the drive flag on every cycle of both ports, not only on selected reads. A corrupted storage word, or the wrong collision winner, stays hidden until that address is read. So every write in the bench is followed within a few cycles by a read of the same location from one port or the other. Drive-flag errors are visible on the first edge after the stimulus, except for the pipelined wake-up rule, which needs two edges to tell apart.

// File: rtl/dpram_pkg.sv
`timescale 1ns/1ps
package dpram_pkg;

  // Strobes from a port's control logic to the storage datapath
  typedef struct packed {
    logic wrEn;      // store the write byte on this edge
    logic pipeMode;  // read path takes the extra output register
  } portStrobe_t;

  // Where the next port address comes from, in priority order
  typedef enum logic [1:0] {
    SRC_HOLD  = 2'd0,
    SRC_STEP  = 2'd1,
    SRC_LOAD  = 2'd2,
    SRC_CLEAR = 2'd3
  } addrSrc_t;

endpackage

// File: rtl/dpram_port_ctrl.sv
`timescale 1ns/1ps
module dpram_port_ctrl import dpram_pkg::*; #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ce0N,
  input  logic              ce1,
  input  logic              rdWrN,
  input  logic              oeN,
  input  logic              pipeMode,
  input  logic              addrClear,
  input  logic              addrLoad,
  input  logic              addrStep,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output portStrobe_t       strobe,
  output logic              drive
);

  logic              selNow;
  addrSrc_t          src;
  logic [ADDR_W-1:0] cnt;
  logic [ADDR_W-1:0] nextAddr;
  logic              readQ;
  logic              pipeDriveQ;
  logic              driveRaw;

  assign selNow = !ce0N && ce1;

  always_comb begin
    if (addrClear)     src = SRC_CLEAR;
    else if (addrLoad) src = SRC_LOAD;
    else if (addrStep) src = SRC_STEP;
    else               src = SRC_HOLD;
  end

  always_comb begin
    unique case (src)
      SRC_CLEAR: nextAddr = '0;
      SRC_LOAD:  nextAddr = addrIn;
      SRC_STEP:  nextAddr = cnt + 1'b1;
      default:   nextAddr = cnt;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cnt <= '0;
    else       cnt <= nextAddr;
  end

  // The write lands on the address chosen at the same edge.
  // Reads use the registered address.
  assign wrAddr          = nextAddr;
  assign rdAddr          = cnt;
  assign strobe.wrEn     = selNow && !rdWrN;
  assign strobe.pipeMode = pipeMode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readQ      <= 1'b0;
      pipeDriveQ <= 1'b0;
    end else begin
      readQ      <= selNow && rdWrN;
      pipeDriveQ <= readQ && selNow;
    end
  end

  assign driveRaw = pipeMode ? pipeDriveQ : readQ;
  assign drive    = driveRaw && !oeN;

  // R7
  desel_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !selNow |=> !driveRaw);

  // R7
  write_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!pipeMode && selNow && !rdWrN) |=> !driveRaw);

  // R8
  pipe_wake_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pipeMode && !selNow) |=> ##1 !driveRaw);

  // R3
  clear_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    addrClear |=> (rdAddr == '0));

  // R3
  load_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!addrClear && addrLoad) |=> (rdAddr == $past(addrIn)));

  // R4
  step_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!addrClear && !addrLoad && addrStep) |=> (rdAddr == ADDR_W'($past(rdAddr) + 1'b1)));

  // R10
  hold_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!addrClear && !addrLoad && !addrStep) |=> $stable(rdAddr));

endmodule

// File: rtl/dpram_core.sv
`timescale 1ns/1ps
module dpram_core import dpram_pkg::*; #(
  parameter int ADDR_W   = 10,
  parameter int DATA_W   = 8,
  parameter int WIN_PORT = 0
) (
  input  logic              clkA,
  input  logic              clkB,
  input  logic              rstN,
  input  portStrobe_t       strobeA,
  input  portStrobe_t       strobeB,
  input  logic [ADDR_W-1:0] wrAddrA,
  input  logic [ADDR_W-1:0] wrAddrB,
  input  logic [ADDR_W-1:0] rdAddrA,
  input  logic [ADDR_W-1:0] rdAddrB,
  input  logic [DATA_W-1:0] wrDataA,
  input  logic [DATA_W-1:0] wrDataB,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB
);

  localparam int DEPTH = 1 << ADDR_W;

  // One bank per writing port. The stored word is the XOR of both banks.
  logic [DATA_W-1:0] bankA [DEPTH];
  logic [DATA_W-1:0] bankB [DEPTH];

  logic collide;
  logic wrGoA;
  logic wrGoB;

  assign collide = strobeA.wrEn && strobeB.wrEn && (wrAddrA == wrAddrB);
  assign wrGoA   = strobeA.wrEn && !(collide && (WIN_PORT == 1));
  assign wrGoB   = strobeB.wrEn && !(collide && (WIN_PORT == 0));

  always_ff @(posedge clkA) begin
    if (wrGoA) bankA[wrAddrA] <= wrDataA ^ bankB[wrAddrA];
  end

  always_ff @(posedge clkB) begin
    if (wrGoB) bankB[wrAddrB] <= wrDataB ^ bankA[wrAddrB];
  end

  logic [1:0]             clkV;
  logic [1:0]             pipeV;
  logic [1:0][ADDR_W-1:0] rdAddrV;
  logic [1:0][DATA_W-1:0] rdOutV;

  assign clkV    = {clkB, clkA};
  assign pipeV   = {strobeB.pipeMode, strobeA.pipeMode};
  assign rdAddrV = {rdAddrB, rdAddrA};

  for (genvar p = 0; p < 2; p++) begin : g_rdPath
    logic [DATA_W-1:0] flowVal;
    logic [DATA_W-1:0] pipeQ;

    assign flowVal = bankA[rdAddrV[p]] ^ bankB[rdAddrV[p]];

    always_ff @(posedge clkV[p]) begin
      pipeQ <= flowVal;
    end

    assign rdOutV[p] = pipeV[p] ? pipeQ : flowVal;
  end

  assign rdDataA = rdOutV[0];
  assign rdDataB = rdOutV[1];

  // R2
  store_a_chk: assert property (@(posedge clkA) disable iff (!rstN)
    wrGoA |=> ((bankA[$past(wrAddrA)] ^ bankB[$past(wrAddrA)]) == $past(wrDataA)));

  // R2
  store_b_chk: assert property (@(posedge clkB) disable iff (!rstN)
    wrGoB |=> ((bankA[$past(wrAddrB)] ^ bankB[$past(wrAddrB)]) == $past(wrDataB)));

  // R12
  winner_chk: assert property (@(posedge clkA) disable iff (!rstN)
    collide |=> ((bankA[$past(wrAddrA)] ^ bankB[$past(wrAddrA)]) ==
                 ((WIN_PORT == 0) ? $past(wrDataA) : $past(wrDataB))));

endmodule

// File: rtl/dpram_sync.sv
`timescale 1ns/1ps
module dpram_sync import dpram_pkg::*; #(
  parameter int ADDR_W   = 10,
  parameter int DATA_W   = 8,
  parameter int WIN_PORT = 0
) (
  input  logic              clkA,
  input  logic              clkB,
  input  logic              rstN,
  input  logic              aCe0N,
  input  logic              aCe1,
  input  logic              aRdWrN,
  input  logic              aOeN,
  input  logic              aPipeMode,
  input  logic              aAddrClear,
  input  logic              aAddrLoad,
  input  logic              aAddrStep,
  input  logic [ADDR_W-1:0] aAddr,
  input  logic [DATA_W-1:0] aWrData,
  output logic [DATA_W-1:0] aRdData,
  output logic              aRdDrive,
  input  logic              bCe0N,
  input  logic              bCe1,
  input  logic              bRdWrN,
  input  logic              bOeN,
  input  logic              bPipeMode,
  input  logic              bAddrClear,
  input  logic              bAddrLoad,
  input  logic              bAddrStep,
  input  logic [ADDR_W-1:0] bAddr,
  input  logic [DATA_W-1:0] bWrData,
  output logic [DATA_W-1:0] bRdData,
  output logic              bRdDrive
);

  portStrobe_t       strobeA;
  portStrobe_t       strobeB;
  logic [ADDR_W-1:0] wrAddrA;
  logic [ADDR_W-1:0] wrAddrB;
  logic [ADDR_W-1:0] rdAddrA;
  logic [ADDR_W-1:0] rdAddrB;

  dpram_port_ctrl #(.ADDR_W(ADDR_W)) u_ctrlA (
    .clk(clkA), .rstN(rstN), .ce0N(aCe0N), .ce1(aCe1), .rdWrN(aRdWrN),
    .oeN(aOeN), .pipeMode(aPipeMode), .addrClear(aAddrClear),
    .addrLoad(aAddrLoad), .addrStep(aAddrStep), .addrIn(aAddr),
    .wrAddr(wrAddrA), .rdAddr(rdAddrA), .strobe(strobeA), .drive(aRdDrive)
  );

  dpram_port_ctrl #(.ADDR_W(ADDR_W)) u_ctrlB (
    .clk(clkB), .rstN(rstN), .ce0N(bCe0N), .ce1(bCe1), .rdWrN(bRdWrN),
    .oeN(bOeN), .pipeMode(bPipeMode), .addrClear(bAddrClear),
    .addrLoad(bAddrLoad), .addrStep(bAddrStep), .addrIn(bAddr),
    .wrAddr(wrAddrB), .rdAddr(rdAddrB), .strobe(strobeB), .drive(bRdDrive)
  );

  dpram_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_PORT(WIN_PORT)) u_core (
    .clkA(clkA), .clkB(clkB), .rstN(rstN),
    .strobeA(strobeA), .strobeB(strobeB),
    .wrAddrA(wrAddrA), .wrAddrB(wrAddrB),
    .rdAddrA(rdAddrA), .rdAddrB(rdAddrB),
    .wrDataA(aWrData), .wrDataB(bWrData),
    .rdDataA(aRdData), .rdDataB(bRdData)
  );

endmodule

// File: tb/test_dpram_sync.sv
`timescale 1ns/1ps
module test_dpram_sync;

  localparam int CLK_PERIOD = 10;
  localparam int AW    = 10;
  localparam int DW    = 8;
  localparam int DEPTH = 1 << AW;
  localparam int WIN   = 0;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [1:0]         ce0N, ce1, rdWrN, oeN, pipeMode, clr, ld, stp;
  logic [1:0][AW-1:0] addr;
  logic [1:0][DW-1:0] wdat;
  logic [1:0][DW-1:0] rdat;
  logic [1:0]         drv;

  dpram_sync #(.ADDR_W(AW), .DATA_W(DW), .WIN_PORT(WIN)) i_dpram_sync (
    .clkA(clk), .clkB(clk), .rstN(rstN),
    .aCe0N(ce0N[0]), .aCe1(ce1[0]), .aRdWrN(rdWrN[0]), .aOeN(oeN[0]),
    .aPipeMode(pipeMode[0]), .aAddrClear(clr[0]), .aAddrLoad(ld[0]),
    .aAddrStep(stp[0]), .aAddr(addr[0]), .aWrData(wdat[0]),
    .aRdData(rdat[0]), .aRdDrive(drv[0]),
    .bCe0N(ce0N[1]), .bCe1(ce1[1]), .bRdWrN(rdWrN[1]), .bOeN(oeN[1]),
    .bPipeMode(pipeMode[1]), .bAddrClear(clr[1]), .bAddrLoad(ld[1]),
    .bAddrStep(stp[1]), .bAddr(addr[1]), .bWrData(wdat[1]),
    .bRdData(rdat[1]), .bRdDrive(drv[1])
  );

  typedef struct {
    int       due;
    int       port;
    bit       chkData;
    bit [7:0] data;
    bit       chkDrv;
    bit       drvExp;
    string    tag;
  } exp_t;

  exp_t     q[$];
  bit [7:0] mem [int];
  int       cntM [2];
  bit       prevRd [2];
  int       cyc = 0;
  int       nChk = 0;
  int       nFail = 0;
  bit       done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string tag, string what, int act, int expv);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", tag, what, act, expv, cyc);
    end
  endtask

  // Monitor: compare the results the design shows against due expectations
  always @(negedge clk) begin
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].due == cyc) begin
        if (q[i].chkData)
          chk(rdat[q[i].port] == q[i].data, q[i].tag,
              $sformatf("port%0d data", q[i].port), int'(rdat[q[i].port]), int'(q[i].data));
        if (q[i].chkDrv)
          chk(drv[q[i].port] == q[i].drvExp, q[i].tag,
              $sformatf("port%0d drive", q[i].port), int'(drv[q[i].port]), int'(q[i].drvExp));
        q.delete(i);
      end
    end
  end

  task automatic setPort(int p, bit sel, bit rd, bit c, bit l, bit s, int a, int d);
    ce0N[p]  = !sel;
    ce1[p]   = sel;
    rdWrN[p] = rd;
    clr[p]   = c;
    ld[p]    = l;
    stp[p]   = s;
    addr[p]  = AW'(a);
    wdat[p]  = DW'(d);
  endtask

  task automatic idle(int p);
    setPort(p, 0, 1, 0, 0, 0, 0, 0);
  endtask

  // Driver: apply the model for the coming edge, queue expectations, advance
  task automatic tick(string tag);
    int nc [2];
    bit sel [2];
    bit wr [2];
    for (int p = 0; p < 2; p++) begin
      if (clr[p])      nc[p] = 0;
      else if (ld[p])  nc[p] = int'(addr[p]);
      else if (stp[p]) nc[p] = (cntM[p] + 1) % DEPTH;
      else             nc[p] = cntM[p];
      sel[p] = !ce0N[p] && ce1[p];
      wr[p]  = sel[p] && !rdWrN[p];
    end
    if (wr[0] && wr[1] && nc[0] == nc[1]) begin
      mem[nc[0]] = (WIN == 0) ? wdat[0] : wdat[1];
    end else begin
      for (int p = 0; p < 2; p++) if (wr[p]) mem[nc[p]] = wdat[p];
    end
    for (int p = 0; p < 2; p++) begin
      exp_t e;
      bit known;
      cntM[p] = nc[p];
      known = mem.exists(nc[p]);
      e.port = p;
      e.tag  = tag;
      if (!pipeMode[p]) begin
        e.due = cyc + 1; e.chkData = known; e.data = known ? mem[nc[p]] : 8'h0;
        e.chkDrv = 1'b1; e.drvExp = sel[p] && rdWrN[p];
        q.push_back(e);
      end else begin
        e.due = cyc + 1; e.chkData = 1'b0; e.data = 8'h0;
        e.chkDrv = 1'b1; e.drvExp = prevRd[p] && sel[p];
        q.push_back(e);
        e.due = cyc + 2; e.chkData = known; e.data = known ? mem[nc[p]] : 8'h0;
        e.chkDrv = 1'b0; e.drvExp = 1'b0;
        q.push_back(e);
        prevRd[p] = sel[p] && rdWrN[p];
      end
    end
    @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nFail++;
      nChk++;
      $display("FAIL watchdog (all requirements): actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
      $finish;
    end
  end

  initial begin
    pipeMode = 2'b10;   // port A flow-through, port B pipelined
    oeN = 2'b00;
    idle(0);
    idle(1);
    cntM[0] = 0; cntM[1] = 0;
    prevRd[0] = 1'b0; prevRd[1] = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    // R1: drive flags low while in reset
    chk(drv[0] == 1'b0, "R1", "port0 drive in reset", int'(drv[0]), 0);
    chk(drv[1] == 1'b0, "R1", "port1 drive in reset", int'(drv[1]), 0);
    rstN = 1'b1;
    #1;
    chk(drv == 2'b00, "R1", "drives after reset", int'(drv), 0);
    tick("R1");
    tick("R1");

    // R2: writes on port A, R5 flow reads on A, R6 pipelined reads on B
    setPort(0, 1, 0, 0, 1, 0, 3, 8'h3C); tick("R2");
    setPort(0, 1, 0, 0, 1, 0, 4, 8'hA5); tick("R2");
    setPort(0, 1, 0, 0, 1, 0, 5, 8'h5A); tick("R2");
    setPort(0, 1, 0, 0, 1, 0, 6, 8'hC3); tick("R2");
    setPort(0, 1, 1, 0, 1, 0, 3, 0); setPort(1, 1, 1, 0, 1, 0, 6, 0); tick("R5");
    setPort(0, 1, 1, 0, 1, 0, 4, 0); setPort(1, 1, 1, 0, 1, 0, 5, 0); tick("R6");
    setPort(0, 1, 1, 0, 1, 0, 5, 0); setPort(1, 1, 1, 0, 1, 0, 4, 0); tick("R6");
    idle(1);

    // R10: address held, output constant
    setPort(0, 1, 1, 0, 1, 0, 4, 0); tick("R10");
    setPort(0, 1, 1, 0, 0, 0, 0, 0); tick("R10");
    tick("R10");
    tick("R10");

    // R3: burst writes and reads through the counter, priority of controls
    setPort(0, 1, 0, 0, 1, 0, 10, 8'h11); tick("R3");
    setPort(0, 1, 0, 0, 0, 1, 0, 8'h12);  tick("R3");
    setPort(0, 1, 0, 0, 0, 1, 0, 8'h13);  tick("R3");
    setPort(0, 1, 0, 0, 0, 1, 0, 8'h14);  tick("R3");
    setPort(0, 1, 1, 0, 1, 0, 10, 0);     tick("R3");
    setPort(0, 1, 1, 0, 0, 1, 0, 0);      tick("R3");
    tick("R3");
    tick("R3");
    setPort(0, 1, 0, 0, 1, 0, 0, 8'h77);  tick("R3");
    setPort(0, 1, 0, 0, 1, 0, 20, 8'h88); tick("R3");
    setPort(0, 1, 1, 1, 1, 1, 20, 0);     tick("R3");  // clear beats load: address 0
    setPort(0, 1, 1, 0, 1, 1, 20, 0);     tick("R3");  // load beats step: address 20

    // R4: counter moves while deselected, and wraps at the top
    setPort(0, 1, 0, 0, 1, 0, 30, 8'h31); tick("R4");
    setPort(0, 1, 0, 0, 1, 0, 31, 8'h32); tick("R4");
    setPort(0, 0, 1, 0, 1, 0, 30, 0);     tick("R4");
    setPort(0, 0, 1, 0, 0, 1, 0, 0);      tick("R4");
    setPort(0, 1, 1, 0, 0, 0, 0, 0);      tick("R4");
    setPort(0, 1, 0, 0, 1, 0, DEPTH - 1, 8'hEE); tick("R4");
    setPort(0, 1, 0, 0, 0, 1, 0, 8'hEF);  tick("R4");
    setPort(0, 1, 1, 0, 1, 0, DEPTH - 1, 0); tick("R4");
    setPort(0, 1, 1, 0, 0, 1, 0, 0);      tick("R4");

    // R7: flow-through drive flag across deselect and write
    setPort(0, 1, 1, 0, 1, 0, 3, 0);      tick("R7");
    idle(0);                              tick("R7");
    setPort(0, 1, 1, 0, 1, 0, 4, 0);      tick("R7");
    setPort(0, 1, 0, 0, 1, 0, 7, 8'h70);  tick("R7");
    setPort(0, 1, 1, 0, 1, 0, 7, 0);      tick("R7");
    idle(0);                              tick("R7");

    // R8: pipelined wake-up needs two selected cycles
    setPort(1, 1, 1, 0, 1, 0, 3, 0); tick("R8");
    setPort(1, 1, 1, 0, 1, 0, 4, 0); tick("R8");
    setPort(1, 1, 1, 0, 1, 0, 5, 0); tick("R8");
    idle(1);                         tick("R8");
    setPort(1, 1, 1, 0, 1, 0, 6, 0); tick("R8");
    idle(1);                         tick("R8");
    setPort(1, 1, 1, 0, 1, 0, 3, 0); tick("R8");
    setPort(1, 1, 1, 0, 1, 0, 4, 0); tick("R8");
    idle(1);                         tick("R8");

    // R9: output enable acts without a clock
    setPort(0, 1, 1, 0, 1, 0, 3, 0); tick("R9");
    oeN[0] = 1'b1;
    #1;
    chk(drv[0] == 1'b0, "R9", "port0 drive with oe high", int'(drv[0]), 0);
    chk(rdat[0] == 8'h3C, "R9", "port0 data with oe high", int'(rdat[0]), 8'h3C);
    oeN[0] = 1'b0;
    #1;
    chk(drv[0] == 1'b1, "R9", "port0 drive with oe low", int'(drv[0]), 1);
    idle(0); tick("R9");

    // R11: cross-port visibility, same edge and later
    setPort(0, 1, 0, 0, 1, 0, 50, 8'hD1); setPort(1, 1, 1, 0, 1, 0, 50, 0); tick("R11");
    idle(0); setPort(1, 1, 0, 0, 1, 0, 60, 8'hD2); tick("R11");
    setPort(0, 1, 1, 0, 1, 0, 60, 0); setPort(1, 1, 0, 0, 1, 0, 61, 8'hD3); tick("R11");
    setPort(0, 1, 1, 0, 1, 0, 61, 0); idle(1); tick("R11");
    setPort(0, 1, 1, 0, 1, 0, 61, 0); setPort(1, 1, 0, 0, 1, 0, 61, 8'hD4); tick("R11");
    idle(0); idle(1); tick("R11");

    // R12: same-address write collision
    setPort(0, 1, 0, 0, 1, 0, 70, 8'hAA); setPort(1, 1, 0, 0, 1, 0, 70, 8'hBB); tick("R12");
    setPort(0, 1, 1, 0, 1, 0, 70, 0); setPort(1, 1, 1, 0, 1, 0, 70, 0); tick("R12");
    setPort(0, 1, 1, 0, 0, 0, 0, 0); tick("R12");
    idle(0); idle(1);
    tick("R12");
    tick("R12");
    tick("R12");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

endmodule